// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block watches banks of 32 general-purpose input pads and turns selected pad activity into interrupt requests. Each line can be told to react to a rising edge, a falling edge, both edges, a high level or a low level. When the chosen condition occurs on a line whose pin-mux function select picks the interrupt function, a sticky status bit is set. Each bank drives one interrupt output, asserted while any line is both pending and enabled.

Software reaches the per-bank registers through a simple write-strobe bus with combinational read data. Each bank owns a 0x20-byte window above 0x200, and a parameter table maps every logical bank onto the hardware window it answers in. Pads pass through a two-stage synchroniser before detection. The pin-mux function select for each pin arrives as an input from the pin-mux logic. Each bank also keeps a debounce word that is stored and read back only.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every trigger-mode word, enable word, status word and debounce word reads 0, and every irq_out bit is 0.
- R2: Logical bank b answers at byte address 0x200 + 0x20*H + offset, where H is the 4-bit entry BANK_MAP[4b+3:4b] (default: bank 0 uses H=1, bank 1 uses H=0). Offsets 0x00, 0x04, 0x08 and 0x0C hold trigger-mode words 0..3, 0x10 the enable word, 0x14 the status word and 0x18 the debounce word. Mode, enable and debounce words read back what was written.
- R3: Line n's trigger mode is bits [4*(n%8)+3:4*(n%8)] of mode word n/8. In mode 0 (rising edge), a 0-to-1 pad change applied before clock edge k sets status bit n at edge k+2, and status is still 0 after edge k+1. A falling change does not set it.
- R4: In mode 1 (falling edge), a 1-to-0 pad change sets the status bit with the same latency as R3. A rising change does not set it.
- R5: In mode 2 (high level) or mode 3 (low level), status is set while the synchronised pad holds that level. A clear written while the level persists leaves the bit at 1. A clear written after the level has gone leaves it at 0.
- R6: In mode 4 (both edges), either pad transition sets the status bit.
- R7: Mode codes 5 to 15 never set a status bit, whatever the pad does.
- R8: A status bit is set only while the pin's 4-bit function select equals 6. With any other value, for example 0 (plain input), pad activity is ignored.
- R9: Status is set whether or not the line's enable bit is 1. irq_out[b] is 1 exactly when some line of bank b has both its status and enable bits at 1, and it follows an enable write with no extra delay.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A condition detected in the same cycle as the clear wins.
- R11: Reads of offsets 0x1C inside a bank window, and of addresses in no mapped bank window, return 0. Writes to them change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_BANKS*32 | Asynchronous pad levels, bank-major |
| pin_func | input | NUM_BANKS*128 | 4-bit function select per pin, bank-major |
| irq_out | output | NUM_BANKS | One combined interrupt per logical bank |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a live detection. A level-mode line produces one every cycle. The stimulus holds a high-level line active, issues the clear and reads the status right after that edge, expecting 1. It then removes the level, waits out the synchroniser and clears again, expecting 0. Remapping is exercised by using bank 0 through the upper window and checking that the lower window, which belongs to bank 1, is unaffected.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int LINES          = 32;
    localparam int MODE_W         = 4;
    localparam int FUNC_W         = 4;
    localparam int MODES_PER_WORD = 8;
    localparam int MODE_WORDS     = LINES / MODES_PER_WORD;
    localparam int DATA_W         = 32;
    localparam logic [31:0] REGION_BASE = 32'h200;
    localparam logic [FUNC_W-1:0] FUNC_IRQ = 4'd6;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    typedef enum logic [2:0] {
        KIND_MODE,
        KIND_EN,
        KIND_STAT,
        KIND_DEB,
        KIND_NONE
    } reg_kind_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] hw_bank;
        reg_kind_e  kind;
        logic [1:0] word;
    } dec_t;

    function automatic logic line_cond(input logic [MODE_W-1:0] mode,
                                       input logic cur, input logic prev);
        logic r;
        case (mode)
            TRIG_RISE: r = cur & ~prev;
            TRIG_FALL: r = ~cur & prev;
            TRIG_HIGH: r = cur;
            TRIG_LOW:  r = ~cur;
            TRIG_BOTH: r = cur ^ prev;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic dec_t decode_addr(input logic [31:0] a);
        dec_t d;
        logic [31:0] off;
        off       = a - REGION_BASE;
        d.hit     = (a >= REGION_BASE) && (off[31:13] == '0) && (off[1:0] == 2'b00);
        d.hw_bank = off[12:5];
        d.word    = off[3:2];
        case (off[4:2])
            3'd0, 3'd1, 3'd2, 3'd3: d.kind = KIND_MODE;
            3'd4:                   d.kind = KIND_EN;
            3'd5:                   d.kind = KIND_STAT;
            3'd6:                   d.kind = KIND_DEB;
            default:                d.kind = KIND_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= d;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic [LINES*MODE_W-1:0] modes,
    input  logic [LINES*FUNC_W-1:0] func,
    input  logic [LINES-1:0]        cur,
    input  logic [LINES-1:0]        prev,
    output logic [LINES-1:0]        hit
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign hit[i] = (func[i*FUNC_W +: FUNC_W] == FUNC_IRQ) &&
                        line_cond(modes[i*MODE_W +: MODE_W], cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    wr,
    input  reg_kind_e               kind,
    input  logic [1:0]              word,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic [LINES-1:0]        cur,
    input  logic [LINES-1:0]        prev,
    input  logic [LINES*FUNC_W-1:0] func,
    output logic                    irq,
    output logic [LINES-1:0]        status_o,
    output logic [LINES*MODE_W-1:0] modes_o
);
    logic [MODE_WORDS-1:0][DATA_W-1:0] mode_q;
    logic [LINES-1:0]  en_q;
    logic [LINES-1:0]  stat_q;
    logic [DATA_W-1:0] deb_q;
    logic [LINES-1:0]  hit;
    logic [LINES-1:0]  clr;
    logic              wr_sel;

    assign wr_sel  = wr && sel;
    assign modes_o = mode_q;

    gpio_irq_detect u_detect (
        .modes (modes_o),
        .func  (func),
        .cur   (cur),
        .prev  (prev),
        .hit   (hit)
    );

    assign clr = (wr_sel && kind == KIND_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            en_q   <= '0;
            stat_q <= '0;
            deb_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | hit;
            if (wr_sel) begin
                case (kind)
                    KIND_MODE: mode_q[word] <= wdata;
                    KIND_EN:   en_q         <= wdata;
                    KIND_DEB:  deb_q        <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (kind)
                KIND_MODE: rdata = mode_q[word];
                KIND_EN:   rdata = en_q;
                KIND_STAT: rdata = stat_q;
                KIND_DEB:  rdata = deb_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign irq      = |(stat_q & en_q);
    assign status_o = stat_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 12,
    parameter logic [NUM_BANKS*4-1:0] BANK_MAP = 8'h01
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_BANKS*32-1:0]        pad_in,
    input  logic [NUM_BANKS*32*4-1:0]      pin_func,
    output logic [NUM_BANKS-1:0]           irq_out
);
    localparam int NPINS = NUM_BANKS * LINES;

    logic [NPINS-1:0]        pad_cur;
    logic [NPINS-1:0]        pad_prev;
    logic [NPINS-1:0]        status_all;
    logic [NPINS*MODE_W-1:0] modes_all;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
    logic [NUM_BANKS-1:0]    sel;
    dec_t                    dec;

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (pad_in),
        .cur  (pad_cur),
        .prev (pad_prev)
    );

    always_comb begin
        logic [31:0] a;
        a   = '0;
        a[ADDR_W-1:0] = bus_addr;
        dec = decode_addr(a);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel[b] = dec.hit && (dec.hw_bank == {4'b0000, BANK_MAP[b*4 +: 4]});

        gpio_irq_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .sel      (sel[b]),
            .wr       (bus_wr),
            .kind     (dec.kind),
            .word     (dec.word),
            .wdata    (bus_wdata),
            .rdata    (bank_rdata[b]),
            .cur      (pad_cur[b*LINES +: LINES]),
            .prev     (pad_prev[b*LINES +: LINES]),
            .func     (pin_func[b*LINES*FUNC_W +: LINES*FUNC_W]),
            .irq      (irq_out[b]),
            .status_o (status_all[b*LINES +: LINES]),
            .modes_o  (modes_all[b*LINES*MODE_W +: LINES*MODE_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            bus_rdata = bus_rdata | bank_rdata[b];
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NUM_BANKS = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_wr,
    input logic [NUM_BANKS*128-1:0]  pin_func,
    input logic [NUM_BANKS-1:0]      irq_out,
    input logic [NUM_BANKS*32-1:0]   status_all,
    input logic [NUM_BANKS*128-1:0]  modes_all
);
    localparam int NPINS = NUM_BANKS * 32;

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_all == '0 && irq_out == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_line
        assert_func_gate_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(status_all[i]) |-> ($past(pin_func[i*4 +: 4]) == 4'd6));

        assert_bad_mode_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(status_all[i]) |-> ($past(modes_all[i*4 +: 4]) <= 4'd4));

        assert_clear_by_write_R10: assert property (@(posedge clk) disable iff (rst)
            $fell(status_all[i]) |-> $past(bus_wr));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (rst)
            irq_out[b] |-> (|status_all[b*32 +: 32]));
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .pin_func   (pin_func),
    .irq_out    (irq_out),
    .status_all (status_all),
    .modes_all  (modes_all)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pad_in = '0;
    logic [255:0] pin_func = '0;
    logic [1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // R2: bank 0 uses hardware window 1, bank 1 uses window 0
    localparam logic [11:0] B0 = 12'h220;
    localparam logic [11:0] B1 = 12'h200;

    always #5 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pin_func(pin_func), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_func(input int pin, input logic [3:0] v);
        pin_func[pin*4 +: 4] = v;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(B0 + 12'h00, d); check("R1 mode word", d, 0);
        rd(B0 + 12'h10, d); check("R1 enable", d, 0);
        rd(B0 + 12'h14, d); check("R1 status", d, 0);
        rd(B1 + 12'h18, d); check("R1 debounce", d, 0);
        check("R1 irq_out", {30'd0, irq_out}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(B1 + 12'h04, 32'h12345678);
        rd(B1 + 12'h04, d); check("R2 mode word readback", d, 32'h12345678);
        wr(B1 + 12'h04, 32'h0);
        wr(B0 + 12'h18, 32'h000000A5);
        rd(B0 + 12'h18, d); check("R2 debounce readback", d, 32'hA5);
        rd(B1 + 12'h18, d); check("R2 other window untouched", d, 0);
        wr(B0 + 12'h10, 32'h80000000);
        rd(B0 + 12'h10, d); check("R2 remapped enable", d, 32'h80000000);
        rd(B1 + 12'h10, d); check("R2 bank1 enable clean", d, 0);
        wr(B0 + 12'h10, 32'h0);
        wr(B0 + 12'h1C, 32'hFFFFFFFF);
        rd(B0 + 12'h1C, d); check("R11 hole reads zero", d, 0);
        wr(12'h240, 32'hFFFFFFFF);
        rd(12'h240, d); check("R11 unmapped reads zero", d, 0);
        rd(B0 + 12'h00, d); check("R11 write had no effect", d, 0);
        // mode words for later tests
        wr(B0 + 12'h00, 32'h00100000);   // line5 mode1
        wr(B0 + 12'h04, 32'h0F540032);   // line8 m2, line9 m3, line12 m4, 13 m5, 14 m15
    endtask

    task automatic t_rise();
        logic [31:0] d;
        set_func(3, 4'd6);
        wr(B0 + 12'h10, 32'h8);
        pad_in[3] = 1'b1;
        step(2);
        rd(B0 + 12'h14, d); check("R3 not yet after two edges", d & 32'h8, 0);
        step(1);
        rd(B0 + 12'h14, d); check("R3 set after third edge", d & 32'h8, 32'h8);
        check("R9 irq on enabled line", {30'd0, irq_out}, 2'b01);
        wr(B0 + 12'h14, 32'h8);
        rd(B0 + 12'h14, d); check("R10 cleared", d & 32'h8, 0);
        check("R10 irq drops", {30'd0, irq_out}, 0);
        pad_in[3] = 1'b0;
        step(4);
        rd(B0 + 12'h14, d); check("R3 falling ignored", d & 32'h8, 0);
        set_func(3, 4'd0);
        wr(B0 + 12'h10, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        set_func(5, 4'd6);
        pad_in[5] = 1'b1;
        step(4);
        rd(B0 + 12'h14, d); check("R4 rising ignored", d & 32'h20, 0);
        pad_in[5] = 1'b0;
        step(2);
        rd(B0 + 12'h14, d); check("R4 not yet", d & 32'h20, 0);
        step(1);
        rd(B0 + 12'h14, d); check("R4 falling sets", d & 32'h20, 32'h20);
        wr(B0 + 12'h14, 32'h20);
        set_func(5, 4'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        set_func(8, 4'd6);
        pad_in[8] = 1'b1;
        step(3);
        rd(B0 + 12'h14, d); check("R5 high level sets", d & 32'h100, 32'h100);
        wr(B0 + 12'h14, 32'h100);
        rd(B0 + 12'h14, d); check("R5 R10 set wins over clear", d & 32'h100, 32'h100);
        pad_in[8] = 1'b0;
        step(3);
        wr(B0 + 12'h14, 32'h100);
        rd(B0 + 12'h14, d); check("R5 clear after level gone", d & 32'h100, 0);
        set_func(8, 4'd0);
        set_func(9, 4'd6);
        step(1);
        rd(B0 + 12'h14, d); check("R5 low level sets", d & 32'h200, 32'h200);
        set_func(9, 4'd0);
        wr(B0 + 12'h14, 32'h200);
        rd(B0 + 12'h14, d); check("R5 low cleared", d & 32'h200, 0);
    endtask

    task automatic t_both();
        logic [31:0] d;
        set_func(12, 4'd6);
        step(3);
        pad_in[12] = 1'b1;
        step(3);
        rd(B0 + 12'h14, d); check("R6 rise sets", d & 32'h1000, 32'h1000);
        wr(B0 + 12'h14, 32'h1000);
        pad_in[12] = 1'b0;
        step(3);
        rd(B0 + 12'h14, d); check("R6 fall sets", d & 32'h1000, 32'h1000);
        wr(B0 + 12'h14, 32'h1000);
        set_func(12, 4'd0);
    endtask

    task automatic t_bad();
        logic [31:0] d;
        set_func(13, 4'd6);
        set_func(14, 4'd6);
        pad_in[14:13] = 2'b11;
        step(4);
        pad_in[14:13] = 2'b00;
        step(4);
        rd(B0 + 12'h14, d); check("R7 codes 5 and 15 inert", d & 32'h6000, 0);
        set_func(13, 4'd0);
        set_func(14, 4'd0);
    endtask

    task automatic t_func();
        logic [31:0] d;
        pad_in[16] = 1'b1;
        step(4);
        rd(B0 + 12'h14, d); check("R8 func 0 ignored", d & 32'h10000, 0);
        pad_in[16] = 1'b0;
        step(4);
        set_func(16, 4'd6);
        pad_in[16] = 1'b1;
        step(3);
        rd(B0 + 12'h14, d); check("R9 status without enable", d & 32'h10000, 32'h10000);
        check("R9 no irq while disabled", {30'd0, irq_out}, 0);
        wr(B0 + 12'h10, 32'h10000);
        check("R9 irq after enable", {30'd0, irq_out}, 2'b01);
        wr(B0 + 12'h14, 32'h0);
        rd(B0 + 12'h14, d); check("R10 zero write keeps", d & 32'h10000, 32'h10000);
        wr(B0 + 12'h14, 32'h10000);
        check("R10 irq cleared", {30'd0, irq_out}, 0);
        wr(B0 + 12'h10, 32'h0);
        set_func(16, 4'd0);
        pad_in[16] = 1'b0;
    endtask

    task automatic t_bank1();
        logic [31:0] d;
        set_func(32, 4'd6);
        wr(B1 + 12'h10, 32'h1);
        pad_in[32] = 1'b1;
        step(3);
        rd(B1 + 12'h14, d); check("R2 bank1 status", d, 32'h1);
        rd(B0 + 12'h14, d); check("R2 bank0 status clean", d, 0);
        check("R9 bank1 irq only", {30'd0, irq_out}, 2'b10);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_level();
        t_both();
        t_bad();
        t_func();
        t_bank1();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule